// File: doc/BRIEF.md
# UART Receive Byte Queue with Status

This block is the receive-side byte store of a memory-mapped serial port. A deserializer hands it one byte per cycle through a valid strobe, along with parity, framing and break indications. A register-read port takes the bytes out again. Besides the data path, the block maintains a packed status word, a data-ready flag, a clear-on-read error status and a DMA busy request. The deserializer, the address decoding and the interrupt logic sit outside. The block only gives them a one-cycle error event pulse and its level outputs.

A stored control byte selects the operating style. With its queue-enable bit set, bytes are queued in a circular store of 16 entries by default. With that bit clear, every byte overwrites a single holding register and the queue is left alone. Writing the control byte with its flush bit set empties the queue, and that bit never stays set in the stored copy. A line break pushes a zero byte in place of data. Storing into a full queue, and reading from an empty one, are flagged as errors.

Top module: `uart_rx_queue`

## Requirements
- R1: `statusWord` packs the queued byte count in bits [7:0], a queue-full flag in bit 8, and in bit 9 a flag that is 1 while any bit of `errStatus` is 1; out of reset it reads 0.
- R2: While the queue holds DEPTH bytes (16 by default), bit 8 of `statusWord` is 1 and bits [7:0] read 0.
- R3: A `ctlWr` with `ctlWrData[1]` = 1 empties the queue and discards a store in the same cycle. `ctlValue` then holds `ctlWrData` with bit 1 forced to 0. The bits of the stored value take effect from the next cycle.
- R4: With `ctlValue[0]` = 0 (holding mode), each stored byte replaces the holding register, which `rdData` shows. The queue and its count are not changed.
- R5: In queue mode, a store into a full queue without a read in the same cycle is dropped and sets the overrun bit. A read of an empty queue gives `rdData` = 0x00 and removes nothing. Each of these two cases raises `errEvent` for exactly the following cycle.
- R6: `dataReady` in queue mode is 1 exactly when the queue holds data after the cycle's store, read and flush. In holding mode it is set by a store, cleared by a read without a store, and otherwise kept.
- R7: `inBreak` stores a 0x00 byte (in either mode), sets `errStatus[3]`, and takes priority over a byte offered in the same cycle.
- R8: `errStatus` holds overrun in bit 0, parity in bit 1, frame in bit 2 and break in bit 3. Parity and frame are taken from `inParityErr` and `inFrameErr` along with a non-break `inValid`. An `errRd` returns the value that cycle and clears it for the next cycle, but errors that arrive in the same cycle as the read are kept.
- R9: `dmaBusy` is 1 exactly when `dmaModeSel` = 2'b10 and the queue holds no byte.
- R10: In queue mode, a store and a read in the same cycle on a non-empty queue both succeed (including when full) and leave the count unchanged.
- R11: In queue mode, bytes leave in arrival order. During a read, `rdData` shows the oldest byte in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Received byte strobe |
| inByte | input | 8 | Received byte |
| inParityErr | input | 1 | Parity error with the byte |
| inFrameErr | input | 1 | Framing error with the byte |
| inBreak | input | 1 | Break condition detected |
| rdStrobe | input | 1 | Data read strobe |
| rdData | output | 8 | Read data, valid with rdStrobe |
| errRd | input | 1 | Error status read strobe |
| errStatus | output | 4 | Error status bits |
| ctlWr | input | 1 | Control write strobe |
| ctlWrData | input | 8 | Control write data |
| ctlValue | output | 8 | Stored control value |
| dmaModeSel | input | 2 | Receive transfer mode field |
| statusWord | output | 10 | Count, full and error flag |
| dataReady | output | 1 | Data available |
| dmaBusy | output | 1 | DMA busy request |
| errEvent | output | 1 | Overflow/underflow event pulse |

## Verification
`rdData` and the pre-clear `errStatus` are combinational answers to the strobes in the same cycle. The bench therefore samples them 1 ns after driving the inputs, half a period before the edge. Every other result (count, full and error flags, `dataReady`, `dmaBusy`, `errEvent`, `ctlValue`, the cleared error status) comes from a register. It is due one clock after the stimulus and is sampled 2 ns after that rising edge. The expected values come from a byte-queue model in the bench, which is stepped on the same edge.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  // control byte bit positions
  localparam int CTL_QUEUE_EN = 0;
  localparam int CTL_FLUSH    = 1;

  // error status bit positions
  localparam int ERR_OVERRUN = 0;
  localparam int ERR_PARITY  = 1;
  localparam int ERR_FRAME   = 2;
  localparam int ERR_BREAK   = 3;
  localparam int ERR_W       = 4;

  localparam logic [1:0] DMA_RX_MODE = 2'b10;

  // strobes from control to datapath
  typedef struct packed {
    logic       push;
    logic       pop;
    logic       flush;
    logic [7:0] pushByte;
  } rxq_strobe_t;
endpackage

// File: rtl/rxq_datapath.sv
module rxq_datapath
  import rxq_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxq_strobe_t       strb,
  output logic [7:0]        headByte,
  output logic [ADDR_W:0]   count,
  output logic              isFull,
  output logic              isEmpty
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0]        mem [DEPTH];
  logic [ADDR_W-1:0] wrPtr, rdPtr, wrPtrNext;
  logic              fullReg;

  assign wrPtrNext = wrPtr + 1'b1;

  always_ff @(posedge clk) begin
    if (strb.push) mem[wrPtr] <= strb.pushByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.flush) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      fullReg <= 1'b0;
    end else begin
      if (strb.push) wrPtr <= wrPtrNext;
      if (strb.pop)  rdPtr <= rdPtr + 1'b1;
      if (strb.push && !strb.pop && (wrPtrNext == rdPtr)) fullReg <= 1'b1;
      else if (strb.pop && !strb.push)                    fullReg <= 1'b0;
    end
  end

  assign headByte = mem[rdPtr];
  assign isFull   = fullReg;
  assign isEmpty  = !fullReg && (wrPtr == rdPtr);
  assign count    = fullReg ? (ADDR_W+1)'(DEPTH) : {1'b0, wrPtr - rdPtr};
endmodule

// File: rtl/rxq_control.sv
module rxq_control
  import rxq_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [7:0]        inByte,
  input  logic              inParityErr,
  input  logic              inFrameErr,
  input  logic              inBreak,
  input  logic              rdStrobe,
  input  logic              errRd,
  input  logic              ctlWr,
  input  logic [7:0]        ctlWrData,
  input  logic [1:0]        dmaModeSel,
  input  logic [7:0]        headByte,
  input  logic [ADDR_W:0]   count,
  input  logic              isFull,
  input  logic              isEmpty,
  output rxq_strobe_t       strb,
  output logic [7:0]        rdData,
  output logic [ERR_W-1:0]  errStatus,
  output logic [7:0]        ctlValue,
  output logic [9:0]        statusWord,
  output logic              dataReady,
  output logic              dmaBusy,
  output logic              errEvent
);
  localparam int CNT_W = ADDR_W + 1;

  logic [7:0]       ctlReg, holdReg;
  logic [ERR_W-1:0] errReg, errSet;
  logic             readyReg, evtReg;
  logic             queueMode, storeReq, flush;
  logic             popOk, pushOk, underflow, overflow;
  logic [7:0]       storeByte;
  logic [CNT_W-1:0] nextCount;

  always_comb begin
    queueMode = ctlReg[CTL_QUEUE_EN];
    storeReq  = inValid | inBreak;
    storeByte = inBreak ? 8'h00 : inByte;
    flush     = ctlWr & ctlWrData[CTL_FLUSH];
    popOk     = queueMode & rdStrobe & !isEmpty;
    underflow = queueMode & rdStrobe & isEmpty;
    pushOk    = queueMode & storeReq & (!isFull | popOk) & !flush;
    overflow  = queueMode & storeReq & isFull & !popOk & !flush;
    nextCount = flush ? '0 : (count + CNT_W'(pushOk) - CNT_W'(popOk));
    errSet                = '0;
    errSet[ERR_OVERRUN]   = overflow;
    errSet[ERR_PARITY]    = inValid & !inBreak & inParityErr;
    errSet[ERR_FRAME]     = inValid & !inBreak & inFrameErr;
    errSet[ERR_BREAK]     = inBreak;
  end

  always_comb begin
    strb.push     = pushOk;
    strb.pop      = popOk & !flush;
    strb.flush    = flush;
    strb.pushByte = storeByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlReg   <= '0;
      holdReg  <= '0;
      errReg   <= '0;
      readyReg <= 1'b0;
      evtReg   <= 1'b0;
    end else begin
      if (ctlWr) begin
        ctlReg            <= ctlWrData;
        ctlReg[CTL_FLUSH] <= 1'b0;
      end
      if (!queueMode && storeReq) holdReg <= storeByte;
      errReg <= (errRd ? '0 : errReg) | errSet;
      evtReg <= overflow | underflow;
      if (queueMode)     readyReg <= (nextCount != '0);
      else if (storeReq) readyReg <= 1'b1;
      else if (rdStrobe) readyReg <= 1'b0;
    end
  end

  assign rdData     = queueMode ? (isEmpty ? 8'h00 : headByte) : holdReg;
  assign errStatus  = errReg;
  assign ctlValue   = ctlReg;
  assign statusWord = {|errReg, isFull, isFull ? 8'h00 : 8'(count)};
  assign dataReady  = readyReg;
  assign dmaBusy    = (dmaModeSel == DMA_RX_MODE) && isEmpty;
  assign errEvent   = evtReg;
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
  import rxq_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [7:0]  inByte,
  input  logic        inParityErr,
  input  logic        inFrameErr,
  input  logic        inBreak,
  input  logic        rdStrobe,
  output logic [7:0]  rdData,
  input  logic        errRd,
  output logic [3:0]  errStatus,
  input  logic        ctlWr,
  input  logic [7:0]  ctlWrData,
  output logic [7:0]  ctlValue,
  input  logic [1:0]  dmaModeSel,
  output logic [9:0]  statusWord,
  output logic        dataReady,
  output logic        dmaBusy,
  output logic        errEvent
);
  rxq_strobe_t       strb;
  logic [7:0]        headByte;
  logic [ADDR_W:0]   count;
  logic              isFull, isEmpty;

  rxq_control #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inByte(inByte),
    .inParityErr(inParityErr), .inFrameErr(inFrameErr), .inBreak(inBreak),
    .rdStrobe(rdStrobe), .errRd(errRd), .ctlWr(ctlWr), .ctlWrData(ctlWrData),
    .dmaModeSel(dmaModeSel), .headByte(headByte), .count(count),
    .isFull(isFull), .isEmpty(isEmpty), .strb(strb), .rdData(rdData),
    .errStatus(errStatus), .ctlValue(ctlValue), .statusWord(statusWord),
    .dataReady(dataReady), .dmaBusy(dmaBusy), .errEvent(errEvent)
  );

  rxq_datapath #(.ADDR_W(ADDR_W)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .headByte(headByte),
    .count(count), .isFull(isFull), .isEmpty(isEmpty)
  );
endmodule

// File: rtl/uart_rx_queue_checker.sv
module uart_rx_queue_checker (
  input logic       clk,
  input logic       rstN,
  input logic       inValid,
  input logic       inBreak,
  input logic       rdStrobe,
  input logic       errRd,
  input logic       ctlWr,
  input logic [7:0] ctlWrData,
  input logic [7:0] ctlValue,
  input logic [3:0] errStatus,
  input logic [9:0] statusWord,
  input logic       errEvent
);
  logic flushNow, storeNow;
  assign flushNow = ctlWr && ctlWrData[1];
  assign storeNow = inValid || inBreak;

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    flushNow |=> (statusWord[8:0] == 9'd0) && !ctlValue[1]);  // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    ctlValue[0] && statusWord[8] && storeNow && !rdStrobe && !flushNow
    |=> errEvent && errStatus[0]);  // R5

  AST_UNDERFLOW_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    ctlValue[0] && rdStrobe && (statusWord[8:0] == 9'd0) |=> errEvent);  // R5

  AST_BREAK_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    inBreak |=> errStatus[3]);  // R7

  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    errRd && !storeNow |=> (errStatus == 4'd0));  // R8

  AST_SAME_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    ctlValue[0] && storeNow && rdStrobe && (statusWord[8:0] != 9'd0) && !flushNow
    |=> $stable(statusWord[8:0]));  // R10
endmodule

bind uart_rx_queue uart_rx_queue_checker u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inBreak(inBreak),
  .rdStrobe(rdStrobe), .errRd(errRd), .ctlWr(ctlWr), .ctlWrData(ctlWrData),
  .ctlValue(ctlValue), .errStatus(errStatus), .statusWord(statusWord),
  .errEvent(errEvent)
);

// File: tb/uart_rx_queue_bench.sv
`timescale 1ns/1ps
module uart_rx_queue_bench;
  localparam int DEPTH = 16;

  logic clk = 1'b0, rstN = 1'b0;
  logic inValid = 0, inParityErr = 0, inFrameErr = 0, inBreak = 0;
  logic rdStrobe = 0, errRd = 0, ctlWr = 0;
  logic [7:0] inByte = 0, ctlWrData = 0;
  logic [1:0] dmaModeSel = 0;
  logic [7:0] rdData, ctlValue;
  logic [3:0] errStatus;
  logic [9:0] statusWord;
  logic dataReady, dmaBusy, errEvent;

  always #4 clk = ~clk;

  uart_rx_queue u_uart_rx_queue (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inByte(inByte),
    .inParityErr(inParityErr), .inFrameErr(inFrameErr), .inBreak(inBreak),
    .rdStrobe(rdStrobe), .rdData(rdData), .errRd(errRd), .errStatus(errStatus),
    .ctlWr(ctlWr), .ctlWrData(ctlWrData), .ctlValue(ctlValue),
    .dmaModeSel(dmaModeSel), .statusWord(statusWord), .dataReady(dataReady),
    .dmaBusy(dmaBusy), .errEvent(errEvent)
  );

  int nChecks = 0, nFail = 0;
  bit done = 0;
  string curTag = "R1";

  // bench model
  logic [7:0] mq[$];
  logic [7:0] mCtl = 0, mHold = 0;
  logic [3:0] mErr = 0;
  logic       mReady = 0, mEvt = 0;

  task automatic chk(input string f, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", curTag, f, act, exp);
    end
  endtask

  function automatic int expStatus();
    int n = mq.size();
    return {22'd0, (mErr != 0), (n == DEPTH), (n == DEPTH) ? 8'd0 : 8'(n)};
  endfunction

  function automatic int expRdData();
    if (mCtl[0]) return (mq.size() == 0) ? 0 : int'(mq[0]);
    return int'(mHold);
  endfunction

  task automatic checkState();
    chk("statusWord(R1)", statusWord, expStatus());
    chk("dataReady(R6)", dataReady, mReady);
    chk("dmaBusy(R9)", dmaBusy, (dmaModeSel == 2'b10) && (mq.size() == 0));
    chk("errEvent(R5)", errEvent, mEvt);
    chk("ctlValue(R3)", ctlValue, mCtl);
    chk("errStatus(R8)", errStatus, mErr);
  endtask

  task automatic step(input logic v, input logic [7:0] b, input logic brk,
                      input logic pe, input logic fe, input logic rd,
                      input logic cw, input logic [7:0] cwd, input logic er);
    logic fm, fl, sr, emp, ful, pop, und, psh, ovf;
    logic [7:0] sb;
    logic [3:0] ne;
    @(negedge clk);
    inValid = v; inByte = b; inBreak = brk; inParityErr = pe; inFrameErr = fe;
    rdStrobe = rd; ctlWr = cw; ctlWrData = cwd; errRd = er;
    #1;
    if (rd) chk("rdData(R11)", rdData, expRdData());
    if (er) chk("errStatus read(R8)", errStatus, mErr);
    fm = mCtl[0]; fl = cw & cwd[1]; sr = v | brk; sb = brk ? 8'h00 : b;
    emp = (mq.size() == 0); ful = (mq.size() == DEPTH);
    pop = fm & rd & !emp; und = fm & rd & emp;
    psh = fm & sr & (!ful | pop) & !fl;
    ovf = fm & sr & ful & !pop & !fl;
    ne = er ? 4'd0 : mErr;
    ne = ne | {brk, v & !brk & fe, v & !brk & pe, ovf};
    @(posedge clk);
    if (fl) mq.delete();
    else begin
      if (pop) void'(mq.pop_front());
      if (psh) mq.push_back(sb);
    end
    if (!fm && sr) mHold = sb;
    if (fm) mReady = (mq.size() != 0);
    else if (sr) mReady = 1'b1;
    else if (rd) mReady = 1'b0;
    mErr = ne;
    mEvt = ovf | und;
    if (cw) mCtl = cwd & 8'hFD;
    #2;
    checkState();
  endtask

  task automatic idle(); step(0, 0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic push(input logic [7:0] b); step(1, b, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic pull(); step(0, 0, 0, 0, 0, 1, 0, 0, 0); endtask
  task automatic wrCtl(input logic [7:0] d); step(0, 0, 0, 0, 0, 0, 1, d, 0); endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    curTag = "R1 reset";
    checkState();
    chk("rdData reset(R4)", rdData, 0);

    // R4: holding mode keeps only the latest byte, queue untouched
    curTag = "R4";
    push(8'h5A);
    push(8'hA5);
    chk("holding count(R4)", statusWord[7:0], 0);
    pull();
    idle();

    // R3: enable with flush, flush bit not kept
    curTag = "R3";
    wrCtl(8'h03);
    chk("flush bit clear(R3)", ctlValue[1], 0);

    // R11: order
    curTag = "R11";
    push(8'h11); push(8'h22); push(8'h33);
    pull(); pull(); pull();

    // R2: fill to full, count reads zero
    curTag = "R2";
    for (int i = 0; i < DEPTH; i++) push(8'(8'h40 + i));
    chk("full count zero(R2)", statusWord[8:0], 9'h100);
    // R5 overflow
    curTag = "R5";
    push(8'hEE);
    // R10 simultaneous store and read while full
    curTag = "R10";
    step(1, 8'h77, 0, 0, 0, 1, 0, 0, 0);
    chk("full kept(R10)", statusWord[8], 1);
    // R3 flush discards same-cycle store
    curTag = "R3";
    step(1, 8'h99, 0, 0, 0, 0, 1, 8'h03, 0);
    // R5 underflow
    curTag = "R5";
    pull();
    idle();
    // R7 break beats a byte
    curTag = "R7";
    step(1, 8'hC3, 1, 1, 1, 0, 0, 0, 0);
    pull();
    // R8 parity and frame, clear on read, new error survives
    curTag = "R8";
    step(1, 8'h01, 0, 1, 1, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1);
    idle();
    // R9 dma busy
    curTag = "R9";
    dmaModeSel = 2'b10;
    pull(); pull();
    idle();
    push(8'h12);
    pull();
    dmaModeSel = 2'b01;
    idle();

    // R6 random mix
    curTag = "R6 random";
    for (int i = 0; i < 4000; i++) begin
      int ph, pv, pr;
      logic cw;
      logic [7:0] cwd;
      ph = (i / 64) % 3;
      pv = (ph == 0) ? 75 : (ph == 1) ? 20 : 50;
      pr = (ph == 0) ? 20 : (ph == 1) ? 75 : 50;
      if (i % 200 == 0) dmaModeSel = 2'($urandom_range(3));
      cw  = ($urandom_range(99) < 1);
      cwd = {6'd0, ($urandom_range(99) < 30), ($urandom_range(99) < 85)};
      step($urandom_range(99) < pv, 8'($urandom), $urandom_range(99) < 2,
           $urandom_range(99) < 5, $urandom_range(99) < 5,
           $urandom_range(99) < pr, cw, cwd, $urandom_range(99) < 10);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule